// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the memory-mapped register face of a SHA-1/MD5 hash accelerator. A host reaches it over a simple synchronous 32-bit bus. Through it the host can load a running digest and byte count, choose the algorithm and options in a control word, and push 64-byte blocks as sixteen 32-bit words. The host then collects the updated digest once the engine reports a result. An active-low level interrupt and a DMA request follow the ready flags, and a self-clearing soft reset brings the whole block back to its initial state.

The compression engine is modelled by a fixed-latency stub with a simple, documented update rule, so every result is predictable. The stub takes blocks through a valid/ready pair: the buffer holds valid and its data steady until the engine takes the block, and the engine is ready only while idle. Hashing can resume mid-message. Software writes back a saved digest and byte count and clears the initial-constants bit, and the engine continues from those values.

Bus timing: a write is taken on the rising edge where `bus_wr` is high. A read issued on an edge shows up on `bus_rdata` with `bus_rvalid` high for the following cycle. Byte offsets: digest words at 0x00+4i (i=0..4), byte count 0x14, control 0x18, data-in window 0x1C+4k (k=0..15, write-only, reads 0), revision 0x5C, configuration 0x60, status 0x64. Any other offset reads 0.

Top module: `hash_regif`

## Requirements
- R1: After reset, control reads 0, configuration reads 0, status reads 1, `irq_n` is 1 and `dma_req` is 0.
- R2: The five digest words and the byte count are read/write registers that return the last value written.
- R3: Control layout is length [31:5], close [4], use-initial-constants [3], SHA-1 select [2] (1 = SHA-1, 0 = MD5), input-ready [1, read-only], output-ready [0]. A write with a nonzero length stores the fields. It sets input-ready when no block is waiting or in the engine.
- R4: While input-ready is 1, writes to the data window fill the block. The 16th write clears input-ready in that same edge and hands the block to the engine. Output-ready rises LATENCY+1 edges after that 16th write. Data writes while input-ready is 0 are ignored.
- R5: On completion, the result depends on the algorithm. For SHA-1, each of words 0..4 becomes base+F. For MD5, words 0..3 become base+F and word 4 is left unchanged. F is the XOR of the 16 data words, and the sum is taken modulo 2^32.
- R6: With use-initial-constants set, the base words are 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0 (MD5 uses the first four) and the base count is 0. Otherwise the base is the loaded digest and count. The new count is base count plus the length field.
- R7: Writing control with bit 0 = 1 clears output-ready. When a result arrives in the same cycle as that write, output-ready stays 1.
- R8: A control write with a zero length field makes the block idle. It clears input-ready and discards any partly written block.
- R9: `irq_n` is 0 exactly when output-ready and interrupt-enable (configuration bit 2) are both 1.
- R10: `dma_req` is 1 exactly when input-ready and DMA-enable (configuration bit 3) are both 1.
- R11: Writing 1 to configuration bit 1 starts a soft reset. Status reads 0 for SRST_CYCLES cycles while every register returns to its reset value. Status then reads 1, and bit 1 clears itself one cycle later.
- R12: The revision register reads major version in [7:4] and minor version in [3:0], zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| irq_n | output | 1 | Active-low level interrupt |
| dma_req | output | 1 | DMA request for the data window |

## Verification
The delicate coincidence is a result arriving, which sets output-ready, in the same edge as a host control write that clears it. The bench times this collision with the fixed latency, writing the clearing word exactly LATENCY+1 edges after the 16th data word. It then expects control to read back with output-ready still 1 and the new length field kept. A second clear with no collision must then drop the flag, which separates set-wins behaviour from a stuck flag.

// File: rtl/hash_regif_pkg.sv
package hash_regif_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DIG_WORDS = 5;
  localparam int unsigned DIN_WORDS = 16;
  localparam int unsigned LEN_W     = 27;

  // byte offsets of the register window
  localparam logic [6:0] OFF_DIG  = 7'h00;
  localparam logic [6:0] OFF_CNT  = 7'h14;
  localparam logic [6:0] OFF_CTRL = 7'h18;
  localparam logic [6:0] OFF_DIN  = 7'h1C;
  localparam logic [6:0] OFF_REV  = 7'h5C;
  localparam logic [6:0] OFF_CFG  = 7'h60;
  localparam logic [6:0] OFF_STAT = 7'h64;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             close;
    logic             cnst;
    logic             sha1;
  } hash_cfg_t;

  function automatic logic [WORD_W-1:0] init_word(input int unsigned idx);
    case (idx)
      0:       init_word = 32'h6745_2301;
      1:       init_word = 32'hEFCD_AB89;
      2:       init_word = 32'h98BA_DCFE;
      3:       init_word = 32'h1032_5476;
      default: init_word = 32'hC3D2_E1F0;
    endcase
  endfunction

endpackage

// File: rtl/hash_din_buf.sv
module hash_din_buf #(
  parameter int unsigned W     = 32,
  parameter int unsigned WORDS = 16,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned CNT_W = $clog2(WORDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [W-1:0]       wr_data,
  output logic               wr_last,
  output logic               blk_valid,
  input  logic               blk_ready,
  output logic [WORDS*W-1:0] blk_data
);

  logic [W-1:0]     mem_q [WORDS];
  logic [CNT_W-1:0] cnt_q;

  assign wr_last = wr_en && (cnt_q == CNT_W'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      blk_valid <= 1'b0;
    end else if (clr) begin
      cnt_q     <= '0;
      blk_valid <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_last) begin
          cnt_q     <= '0;
          blk_valid <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (blk_valid && blk_ready) begin
        blk_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign blk_data[g*W +: W] = mem_q[g];
  end

  // a waiting block keeps its data until the engine takes it
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready && !clr) |=> (blk_valid && $stable(blk_data))); // R4

endmodule

// File: rtl/hash_core_stub.sv
module hash_core_stub
  import hash_regif_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned WORDS   = 16,
  parameter int unsigned NDIG    = 5,
  parameter int unsigned LW      = 27,
  parameter int unsigned LATENCY = 8,
  localparam int unsigned TW     = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [WORDS*W-1:0] blk_data,
  input  logic [NDIG*W-1:0] base_dig,
  input  logic [W-1:0]      base_cnt,
  input  logic              sel_sha1,
  input  logic              sel_cnst,
  input  logic [LW-1:0]     xfer_len,
  output logic              busy,
  output logic              done,
  output logic [NDIG*W-1:0] res_dig,
  output logic [W-1:0]      res_cnt
);

  localparam int unsigned MD5_WORDS = NDIG - 1;

  logic [TW-1:0]     timer_q;
  logic [W-1:0]      fold;
  logic [NDIG*W-1:0] next_dig;
  logic [W-1:0]      next_cnt;

  always_comb begin
    fold = '0;
    for (int k = 0; k < WORDS; k++) fold = fold ^ blk_data[k*W +: W];
  end

  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      logic [W-1:0] base;
      base = base_dig[i*W +: W];
      if (sel_cnst && (sel_sha1 || i < MD5_WORDS)) base = init_word(i);
      if (sel_sha1 || i < MD5_WORDS) next_dig[i*W +: W] = base + fold;
      else                           next_dig[i*W +: W] = base;
    end
    next_cnt = (sel_cnst ? '0 : base_cnt) + W'(xfer_len);
  end

  assign blk_ready = !busy;
  assign done      = busy && (timer_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      timer_q <= '0;
      res_dig <= '0;
      res_cnt <= '0;
    end else if (abort) begin
      busy    <= 1'b0;
      timer_q <= '0;
    end else if (blk_valid && !busy) begin
      busy    <= 1'b1;
      timer_q <= TW'(LATENCY - 1);
      res_dig <= next_dig;
      res_cnt <= next_cnt;
    end else if (busy) begin
      if (timer_q == '0) busy <= 1'b0;
      else               timer_q <= timer_q - 1'b1;
    end
  end

endmodule

// File: rtl/hash_srst_ctrl.sv
module hash_srst_ctrl #(
  parameter int unsigned CYCLES = 4,
  localparam int unsigned CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic complete
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      complete <= 1'b1;
      cnt_q    <= '0;
    end else if (start) begin
      active   <= 1'b1;
      complete <= 1'b0;
      cnt_q    <= CW'(CYCLES - 1);
    end else if (active) begin
      if (cnt_q == '0) begin
        active   <= 1'b0;
        complete <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/hash_regif.sv
module hash_regif
  import hash_regif_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned LATENCY     = 8,
  parameter int unsigned SRST_CYCLES = 4,
  parameter logic [3:0]  REV_MAJOR   = 4'd1,
  parameter logic [3:0]  REV_MINOR   = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_n,
  output logic              dma_req
);

  localparam int unsigned W         = WORD_W;
  localparam int unsigned DIG_IDX_W = $clog2(DIG_WORDS);
  localparam int unsigned DIN_IDX_W = $clog2(DIN_WORDS);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIN);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFF_REV);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_DIG  = ADDR_W'(OFF_DIG);

  // register state
  logic [W-1:0]  dig_q [DIG_WORDS];
  logic [W-1:0]  cnt_q;
  hash_cfg_t     cfg_q;
  logic          in_rdy_q, out_rdy_q;
  logic          dma_en_q, irq_en_q, srst_q, autoidle_q;

  // decode
  logic                 aligned, is_dig, is_din;
  logic [DIG_IDX_W-1:0] dig_idx;
  logic [DIN_IDX_W-1:0] din_idx;
  logic                 wr_ctrl, wr_cfg, wr_cnt, ctrl_zero_len;

  assign aligned       = (bus_addr[1:0] == 2'b00);
  assign is_dig        = aligned && (bus_addr >= A_DIG) && (bus_addr < A_CNT);
  assign is_din        = aligned && (bus_addr >= A_DIN) && (bus_addr < A_REV);
  assign dig_idx       = DIG_IDX_W'(bus_addr >> 2);
  assign din_idx       = DIN_IDX_W'((bus_addr - A_DIN) >> 2);
  assign wr_ctrl       = bus_wr && (bus_addr == A_CTRL);
  assign wr_cfg        = bus_wr && (bus_addr == A_CFG);
  assign wr_cnt        = bus_wr && (bus_addr == A_CNT);
  assign ctrl_zero_len = (bus_wdata[31:5] == '0);

  // sub-block wiring
  logic                    srst_active, srst_done, srst_start;
  logic                    din_wr, din_last, din_clr, din_valid, core_ready;
  logic [DIN_WORDS*W-1:0]  blk_data;
  logic [DIG_WORDS*W-1:0]  dig_flat, res_dig;
  logic [W-1:0]            res_cnt;
  logic                    core_busy, core_done;

  assign srst_start = wr_cfg && bus_wdata[1];
  assign din_wr     = bus_wr && is_din && in_rdy_q && !srst_active;
  assign din_clr    = srst_active || (wr_ctrl && ctrl_zero_len);

  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_dig_flat
    assign dig_flat[g*W +: W] = dig_q[g];
  end

  hash_srst_ctrl #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (srst_start),
    .active   (srst_active),
    .complete (srst_done)
  );

  hash_din_buf #(.W(W), .WORDS(DIN_WORDS)) u_din (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (din_clr),
    .wr_en     (din_wr),
    .wr_idx    (din_idx),
    .wr_data   (bus_wdata),
    .wr_last   (din_last),
    .blk_valid (din_valid),
    .blk_ready (core_ready),
    .blk_data  (blk_data)
  );

  hash_core_stub #(
    .W(W), .WORDS(DIN_WORDS), .NDIG(DIG_WORDS), .LW(LEN_W), .LATENCY(LATENCY)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (srst_active),
    .blk_valid (din_valid),
    .blk_ready (core_ready),
    .blk_data  (blk_data),
    .base_dig  (dig_flat),
    .base_cnt  (cnt_q),
    .sel_sha1  (cfg_q.sha1),
    .sel_cnst  (cfg_q.cnst),
    .xfer_len  (cfg_q.len),
    .busy      (core_busy),
    .done      (core_done),
    .res_dig   (res_dig),
    .res_cnt   (res_cnt)
  );

  // register update; later statements take priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIG_WORDS; i++) dig_q[i] <= '0;
      cnt_q      <= '0;
      cfg_q      <= '0;
      in_rdy_q   <= 1'b0;
      out_rdy_q  <= 1'b0;
      dma_en_q   <= 1'b0;
      irq_en_q   <= 1'b0;
      autoidle_q <= 1'b0;
      srst_q     <= 1'b0;
    end else if (srst_active) begin
      for (int i = 0; i < DIG_WORDS; i++) dig_q[i] <= '0;
      cnt_q      <= '0;
      cfg_q      <= '0;
      in_rdy_q   <= 1'b0;
      out_rdy_q  <= 1'b0;
      dma_en_q   <= 1'b0;
      irq_en_q   <= 1'b0;
      autoidle_q <= 1'b0;
    end else begin
      if (bus_wr && is_dig) begin
        for (int i = 0; i < DIG_WORDS; i++)
          if (dig_idx == DIG_IDX_W'(i)) dig_q[i] <= bus_wdata;
      end
      if (wr_cnt) cnt_q <= bus_wdata;
      if (wr_ctrl) begin
        cfg_q.len   <= bus_wdata[31:5];
        cfg_q.close <= bus_wdata[4];
        cfg_q.cnst  <= bus_wdata[3];
        cfg_q.sha1  <= bus_wdata[2];
        if (ctrl_zero_len)                in_rdy_q <= 1'b0;
        else if (!din_valid && !core_busy) in_rdy_q <= 1'b1;
        if (bus_wdata[0]) out_rdy_q <= 1'b0;
      end
      if (wr_cfg) begin
        dma_en_q   <= bus_wdata[3];
        irq_en_q   <= bus_wdata[2];
        autoidle_q <= bus_wdata[0];
        if (bus_wdata[1]) srst_q <= 1'b1;
      end else if (srst_q && srst_done) begin
        srst_q <= 1'b0;
      end
      if (din_last) in_rdy_q <= 1'b0;
      if (core_done) begin
        for (int i = 0; i < DIG_WORDS; i++) dig_q[i] <= res_dig[i*W +: W];
        cnt_q     <= res_cnt;
        out_rdy_q <= 1'b1;
      end
    end
  end

  // read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (is_dig) begin
      rd_mux = dig_q[dig_idx];
    end else begin
      case (bus_addr)
        A_CNT:   rd_mux = cnt_q;
        A_CTRL:  rd_mux = {cfg_q.len, cfg_q.close, cfg_q.cnst, cfg_q.sha1, in_rdy_q, out_rdy_q};
        A_REV:   rd_mux = {24'd0, REV_MAJOR, REV_MINOR};
        A_CFG:   rd_mux = {28'd0, dma_en_q, irq_en_q, srst_q, autoidle_q};
        A_STAT:  rd_mux = {31'd0, srst_done};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq_n   = !(out_rdy_q && irq_en_q);
  assign dma_req = in_rdy_q && dma_en_q;

  AST_OUT_RDY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy_q) |-> $past(core_done)); // R4
  AST_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy_q |-> !core_busy); // R3
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && irq_en_q && !srst_active) |=> !irq_n); // R9
  AST_DMA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    din_last |=> !dma_req); // R10
  AST_SRST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> srst_done); // R11

endmodule

// File: tb/test_hash_regif.sv
`timescale 1ns/1ps
module test_hash_regif;

  localparam int unsigned LAT  = 8;
  localparam int unsigned SRST = 4;
  localparam logic [6:0] O_CNT = 7'h14, O_CTRL = 7'h18, O_DIN = 7'h1C,
                         O_REV = 7'h5C, O_CFG = 7'h60, O_STAT = 7'h64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_n, dma_req;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          chk_q[$];

  always #2.5 clk = ~clk;

  hash_regif #(.ADDR_W(7), .LATENCY(LAT), .SRST_CYCLES(SRST),
               .REV_MAJOR(4'd3), .REV_MINOR(4'd7)) i_hash_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_n(irq_n), .dma_req(dma_req)
  );

  // scoreboard monitor: compares each returned read with its queued expectation
  always @(negedge clk) begin
    if (bus_rvalid && exp_q.size() > 0) begin
      logic [31:0] e; string t; bit c;
      e = exp_q.pop_front(); t = tag_q.pop_front(); c = chk_q.pop_front();
      if (c) begin
        tests++;
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic rd_issue(input logic [6:0] a, input bit chk, input logic [31:0] e, input string t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(chk);
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [31:0] e, input string t);
    rd_issue(a, 1'b1, e, t);
  endtask

  task automatic rd_get(input logic [6:0] a, output logic [31:0] v);
    rd_issue(a, 1'b0, '0, "poll");
    v = bus_rdata;
  endtask

  task automatic pin_chk(input logic act, input logic e, input string t);
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: pin %b expected %b", t, act, e);
    end
  endtask

  task automatic wait_bit0(input logic [6:0] a);
    logic [31:0] v;
    for (int n = 0; n < 60; n++) begin
      rd_get(a, v);
      if (v[0]) break;
    end
  endtask

  function automatic logic [31:0] iv(input int i);
    logic [31:0] t[5] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
    return t[i];
  endfunction

  function automatic logic [31:0] pat(input logic [31:0] seed, input int k);
    return (seed ^ (32'(k) * 32'h0103_0507)) + 32'(k);
  endfunction

  function automatic logic [31:0] fold_of(input logic [31:0] seed);
    logic [31:0] f = '0;
    for (int k = 0; k < 16; k++) f ^= pat(seed, k);
    return f;
  endfunction

  task automatic push_block(input logic [31:0] seed, input int n);
    for (int k = 0; k < n; k++) wr(O_DIN + 7'(4*k), pat(seed, k));
  endtask

  localparam logic [31:0] SA = 32'hA5A5_0001, SB = 32'h3C3C_7702,
                          SC = 32'h0F0F_1234, SD = 32'h9999_4321;

  initial begin
    logic [31:0] ld [5];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 / R12: reset values
    pin_chk(irq_n, 1'b1, "R1 irq_n");
    pin_chk(dma_req, 1'b0, "R1 dma_req");
    rd_chk(O_CTRL, 32'h0, "R1 ctrl");
    rd_chk(O_CFG, 32'h0, "R1 cfg");
    rd_chk(O_STAT, 32'h1, "R1 status");
    rd_chk(O_REV, 32'h37, "R12 revision");

    // R2: digest and count storage
    for (int i = 0; i < 5; i++) begin
      ld[i] = 32'h1000_0000 * 32'(i + 1) + 32'h55;
      wr(7'(4*i), ld[i]);
    end
    wr(O_CNT, 32'd100);
    for (int i = 0; i < 5; i++) rd_chk(7'(4*i), ld[i], "R2 digest");
    rd_chk(O_CNT, 32'd100, "R2 count");

    // R3 / R10: arm a SHA-1 first block with initial constants
    wr(O_CFG, 32'hC);
    wr(O_CTRL, (32'd64 << 5) | 32'hC);
    rd_chk(O_CTRL, (32'd64 << 5) | 32'hE, "R3 armed");
    pin_chk(dma_req, 1'b1, "R10 dma_req armed");

    // R4: 16 words, input-ready drops at once
    push_block(SA, 16);
    rd_chk(O_CTRL, (32'd64 << 5) | 32'hC, "R4 in_rdy cleared");
    pin_chk(dma_req, 1'b0, "R10 dma_req idle");
    wait_bit0(O_CTRL);
    pin_chk(irq_n, 1'b0, "R9 irq asserted");
    for (int i = 0; i < 5; i++) rd_chk(7'(4*i), iv(i) + fold_of(SA), "R6 sha1 from constants");
    rd_chk(O_CNT, 32'd64, "R6 count from zero");

    // R7 / R8: clear output-ready with a zero-length write
    wr(O_CTRL, 32'h1);
    rd_chk(O_CTRL, 32'h0, "R8 idle after zero length");
    pin_chk(irq_n, 1'b1, "R7 irq released");

    // R5 / R7: MD5 continuation, clear collides with result
    for (int i = 0; i < 5; i++) wr(7'(4*i), ld[i]);
    wr(O_CNT, 32'd100);
    wr(O_CTRL, 32'd64 << 5);
    push_block(SB, 16);
    repeat (LAT) @(posedge clk);
    wr(O_CTRL, (32'd64 << 5) | 32'h1);
    rd_chk(O_CTRL, (32'd64 << 5) | 32'h1, "R7 set wins on collision");
    for (int i = 0; i < 4; i++) rd_chk(7'(4*i), ld[i] + fold_of(SB), "R5 md5 word");
    rd_chk(7'h10, ld[4], "R5 md5 word4 unchanged");
    rd_chk(O_CNT, 32'd164, "R6 continued count");
    wr(O_CTRL, 32'h1);
    rd_chk(O_CTRL, 32'h0, "R7 clear without collision");

    // R4: data writes ignored while not armed
    push_block(SC, 16);
    repeat (LAT + 4) @(posedge clk);
    rd_chk(O_CTRL, 32'h0, "R4 ignored data no result");
    rd_chk(7'h00, ld[0] + fold_of(SB), "R4 ignored data digest kept");

    // R8: zero-length write discards a partial block
    wr(O_CTRL, (32'd64 << 5) | 32'hC);
    pin_chk(dma_req, 1'b1, "R10 dma_req rearmed");
    push_block(SC, 3);
    wr(O_CTRL, 32'h0);
    rd_chk(O_CTRL, 32'h0, "R8 partial dropped idle");
    pin_chk(dma_req, 1'b0, "R8 dma_req idle");
    wr(O_CTRL, (32'd64 << 5) | 32'hC);
    push_block(SD, 16);
    wait_bit0(O_CTRL);
    rd_chk(7'h00, iv(0) + fold_of(SD), "R8 fresh block only");
    rd_chk(O_CNT, 32'd64, "R8 fresh count");

    // R9: interrupt gated by enable
    wr(O_CFG, 32'h0);
    pin_chk(irq_n, 1'b1, "R9 irq masked");
    wr(O_CFG, 32'h4);
    pin_chk(irq_n, 1'b0, "R9 irq unmasked");

    // R11: soft reset
    wr(O_CFG, 32'h6);
    rd_chk(O_STAT, 32'h0, "R11 status busy");
    wait_bit0(O_STAT);
    rd_chk(O_CFG, 32'h0, "R11 self clear");
    rd_chk(O_CTRL, 32'h0, "R11 ctrl reset");
    rd_chk(7'h00, 32'h0, "R11 digest reset");
    rd_chk(O_CNT, 32'h0, "R11 count reset");
    pin_chk(irq_n, 1'b1, "R11 irq released");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule